// File: doc/BRIEF.md
# Programmed Image Checksum Engine

This block produces the 16-bit verification checksum of a programmed memory image. A fetch unit elsewhere streams the image words to it over a valid/ready interface. Each word carries a two-bit tag that says what kind of word it is: a program word, the configuration word, or one of the four user ID words. Program words arrive in ascending address order. The configuration word may come before or after them. The four ID words come last, with ID0 first.

The engine keeps separate running values for the program sum, the configuration word and the packed ID nibbles. When the fourth ID word is accepted, it reads the code-protect bit of the stored configuration word and chooses the formula. With protection off, the result is the program-word sum plus the masked configuration word. With protection on, it is the masked configuration word plus the packed ID value. The result is registered and flagged with a one-cycle done pulse. It then holds until the next start pulse.

Top module: `csum_engine`

## Requirements
- R1: A start pulse clears the checksum output to 0 and drops done. In the next cycle in_ready is 1, and the engine accepts words until the fourth ID word is taken.
- R2: With protection off, the result is the sum of the accepted in-range program words plus (configuration word AND 0x21FF). The ID words do not contribute.
- R3: With protection on, the result is (configuration word AND 0x21FF) plus a packed ID value, and program words do not contribute. The packed ID value is built from the low 4 bits of each ID word, with ID0 in bits 15:12 and ID3 in bits 3:0.
- R4: Protection is on exactly when bit 13 of the stored configuration word is 0.
- R5: size_sel sets the number of program words that count: 0 selects 1024, 1 selects 2048, and 2 or 3 select 4096. Program words accepted after that many are ignored.
- R6: All additions wrap modulo 2^16 and discard carries.
- R7: The tag encoding is 0 for a program word, 1 for the configuration word, 2 for an ID word and 3 for a reserved value. Words tagged 3 are ignored. When several configuration words are sent, the last one accepted before the fourth ID word is used.
- R8: done is high for exactly one cycle, the cycle after the fourth ID word is accepted. In that same cycle checksum shows the result and in_ready is 0. The checksum then holds until the next start.
- R9: While in_ready is 0, words offered on the input are ignored.
- R10: After reset, checksum is 0, done is 0 and in_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears the accumulators and opens a new pass |
| size_sel | input | 2 | Device size code: 0 = 1K, 1 = 2K, 2 or 3 = 4K words |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Engine accepts a word this cycle |
| in_tag | input | 2 | Word kind: 0 program, 1 configuration, 2 ID, 3 reserved |
| in_word | input | 14 | Word value |
| checksum | output | 16 | Final checksum, valid from the done cycle until the next start |
| done | output | 1 | One-cycle pulse when the result is ready |

## Verification
The bench covers the blank 1K, 2K and 4K images, where the program sum wraps many times. A design that kept carries or picked the wrong word limit gives values other than 0x1DFF, 0x19FF and 0x11FF. A protected image whose configuration word masks to zero shows the ID nibbles alone, so a reversed nibble order or leftover high ID bits is visible, and the large program sum in that image must not appear in the result. One stream sends more words than the selected size, and one sends reserved-tag words and two configuration words. These expose a counter that does not stop at the limit, a decoder that treats tag 3 as program data, and a design that keeps the first configuration word instead of the last. Further checks offer words while the engine is idle, and look at done and checksum one cycle after the pulse. These catch a design that accepts idle input, a done pulse longer than one cycle, and a result that drifts after the pulse.

// File: rtl/csum_engine.sv
module csum_engine #(
  parameter int WORD_W = 14,
  parameter int SUM_W = 16,
  parameter int IDX_W = 13,
  parameter int BASE_WORDS = 1024,
  parameter int CP_BIT = 13,
  parameter logic [SUM_W-1:0] CFG_MASK = 16'h21FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        size_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_tag,
  input  logic [WORD_W-1:0] in_word,
  output logic [SUM_W-1:0]  checksum,
  output logic              done
);
  localparam int NIB_W = 4;
  localparam logic [1:0] TAG_PROG = 2'd0;
  localparam logic [1:0] TAG_CFG  = 2'd1;
  localparam logic [1:0] TAG_ID   = 2'd2;

  logic              active;
  logic [IDX_W-1:0]  idx;
  logic [SUM_W-1:0]  psum, idpack;
  logic [WORD_W-1:0] cfg;
  logic [1:0]        idcnt;
  logic [1:0]        eff_sel;
  logic [IDX_W-1:0]  limit;
  logic [SUM_W-1:0]  cfg_term, id_next, result;
  logic              take, last_id, protect;

  assign in_ready = active;
  assign take     = in_valid & active;
  assign eff_sel  = (size_sel == 2'd3) ? 2'd2 : size_sel;
  assign limit    = IDX_W'(BASE_WORDS) << eff_sel;
  assign cfg_term = SUM_W'(cfg) & CFG_MASK;
  assign protect  = ~cfg[CP_BIT];
  assign id_next  = {idpack[SUM_W-NIB_W-1:0], in_word[NIB_W-1:0]};
  assign last_id  = take && in_tag == TAG_ID && idcnt == 2'd3;
  assign result   = protect ? cfg_term + id_next : psum + cfg_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      idx      <= '0;
      psum     <= '0;
      idpack   <= '0;
      cfg      <= '1;
      idcnt    <= '0;
      checksum <= '0;
      done     <= 1'b0;
    end else if (start) begin
      active   <= 1'b1;
      idx      <= '0;
      psum     <= '0;
      idpack   <= '0;
      cfg      <= '1;
      idcnt    <= '0;
      checksum <= '0;
      done     <= 1'b0;
    end else begin
      done <= last_id;
      if (take) begin
        case (in_tag)
          TAG_PROG: if (idx < limit) begin
            psum <= psum + SUM_W'(in_word);
            idx  <= idx + 1'b1;
          end
          TAG_CFG: cfg <= in_word;
          TAG_ID: begin
            idpack <= id_next;
            idcnt  <= idcnt + 1'b1;
          end
          default: ;
        endcase
      end
      if (last_id) begin
        checksum <= result;
        active   <= 1'b0;
      end
    end
  end
endmodule

module csum_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        in_valid,
  input logic        in_ready,
  input logic [1:0]  in_tag,
  input logic [15:0] checksum,
  input logic        done
);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_ready_low_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);
  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (checksum == 16'd0 && !done && in_ready));
  a_r8_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !(in_valid && in_ready && in_tag == 2'd2)) |=> $stable(checksum));
  a_r9_idle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !start) |=> (!in_ready && !done));
endmodule

bind csum_engine csum_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
  .in_ready(in_ready), .in_tag(in_tag), .checksum(checksum), .done(done)
);

// File: tb/csum_engine_test.sv
module csum_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  size_sel = 2'd0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_tag = 2'd0;
  logic [13:0] in_word = '0;
  logic [15:0] checksum;
  logic        done;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  csum_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag),
    .in_word(in_word), .checksum(checksum), .done(done)
  );

  typedef struct packed {
    logic [1:0]  size;
    logic [12:0] nwords;
    logic [13:0] fill;
    logic [13:0] cfg;
    logic [55:0] ids;
    logic        cfg_first;
    logic [15:0] expv;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 13'd2048, 14'h3FFF, 14'h3FFF, {4{14'h3FFF}}, 1'b0, 16'h19FF},
    '{2'd0, 13'd1024, 14'h3FFF, 14'h3FFF, {4{14'h3FFF}}, 1'b1, 16'h1DFF},
    '{2'd2, 13'd4096, 14'h3FFF, 14'h3FFF, {4{14'h3FFF}}, 1'b0, 16'h11FF},
    '{2'd1, 13'd2048, 14'h3FFF, 14'h1FFF, {14'h0001, 14'h0002, 14'h0003, 14'h0004}, 1'b0, 16'h1433},
    '{2'd0, 13'd1030, 14'h0001, 14'h3FFF, {4{14'h3FF5}}, 1'b0, 16'h25FF},
    '{2'd1, 13'd2048, 14'h1234, 14'h1E00, {14'h3FFA, 14'h0015, 14'h0C03, 14'h00F0}, 1'b1, 16'hA530}
  };
  localparam string VTAG [NV] = '{"R6 blank 2K", "R5 blank 1K", "R5 blank 4K",
                                  "R3 protected IDs", "R5 overlength", "R4 masked cfg"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send(input logic [1:0] tag, input logic [13:0] w);
    @(negedge clk);
    in_valid = 1'b1; in_tag = tag; in_word = w;
  endtask

  task automatic finish_pass(input string tag, input logic [15:0] expv);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R8 done"}, {31'd0, done}, 32'd1);
    check({tag, " R8 ready low"}, {31'd0, in_ready}, 32'd0);
    check({tag, " R2 result"}, {16'd0, checksum}, {16'd0, expv});
    @(negedge clk);
    check({tag, " R8 done single"}, {31'd0, done}, 32'd0);
    check({tag, " R8 hold"}, {16'd0, checksum}, {16'd0, expv});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset checksum", {16'd0, checksum}, 32'd0);
    check("R10 reset done", {31'd0, done}, 32'd0);
    check("R10 reset ready", {31'd0, in_ready}, 32'd0);
    rst_n = 1'b1;

    for (int k = 0; k < 4; k++) begin
      send(2'd2, 14'h000F);
      check("R9 idle no done", {31'd0, done}, 32'd0);
    end
    @(negedge clk); in_valid = 1'b0;
    check("R9 idle checksum", {16'd0, checksum}, 32'd0);
    check("R9 idle done", {31'd0, done}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      size_sel = VECS[v].size;
      pulse_start();
      check("R1 ready after start", {31'd0, in_ready}, 32'd1);
      check("R1 cleared", {16'd0, checksum}, 32'd0);
      if (VECS[v].cfg_first) send(2'd1, VECS[v].cfg);
      for (int i = 0; i < int'(VECS[v].nwords); i++) send(2'd0, VECS[v].fill);
      if (!VECS[v].cfg_first) send(2'd1, VECS[v].cfg);
      for (int k = 0; k < 4; k++) send(2'd2, VECS[v].ids[55 - 14*k -: 14]);
      finish_pass(VTAG[v], VECS[v].expv);
    end

    // R7: reserved tag ignored, last configuration word wins
    size_sel = 2'd0;
    pulse_start();
    send(2'd3, 14'h0100);
    send(2'd3, 14'h0100);
    send(2'd1, 14'h1FFF);
    send(2'd0, 14'h0005);
    send(2'd1, 14'h3FFF);
    for (int k = 0; k < 4; k++) send(2'd2, 14'h0000);
    finish_pass("R7 tags", 16'h2204);

    pulse_start();
    check("R1 restart clears", {16'd0, checksum}, 32'd0);
    check("R1 restart ready", {31'd0, in_ready}, 32'd1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule